// File: doc/BRIEF.md
# Scan-List Acquisition Sequencer with Pacer

This block drives an external analog converter from a host-programmed list of conversion entries. Each entry names a channel, a gain code, a differential flag and a start flag. Once the host arms the block, it steps through the list. For each entry it presents the entry's fields on the converter select outputs and raises a one-cycle convert strobe. A programmable pacer decides when entries carrying the start flag may go. Entries without the flag follow as soon as the converter reports that it is free.

Setting the start flag on every entry paces each conversion on its own. Setting it only on the first entry paces whole scans, and the rest of the scan runs back to back. In one-shot mode the list runs once and the block returns to idle. In continuous mode the list wraps until the host stops the block. A sticky end-of-scan flag and a maskable interrupt level report scan completion. The host reads the status byte directly from an output port.

The host writes through a byte-wide write port. The offsets are: 0 entry port, 1 control, 2/3/4 pacer period low/middle/high, 5 command.

Top module: `scan_sequencer`

## Requirements
- R1: An entry is written as two bytes to offset 0, low byte first. Low bit 7 is the start flag. High bits 3:0 are the channel, high bits 5:4 the gain and high bit 6 the differential flag (entry bits 11:8, 13:12, 14, 7). The fields of the issued entry appear on `convChan`, `convGain` and `convDiff` in the same cycle as its `convStrobe` and hold until the next strobe.
- R2: An entry with the start flag waits for a pacer tick. The first such strobe after an accepted arm appears period×divider+1 cycles after the cycle following the arm write. An entry without the flag issues as soon as the converter is free, so unbusy back-to-back strobes are two cycles apart.
- R3: The pacer period is a 24-bit count written as bytes at offsets 2 (bits 7:0), 3 (bits 15:8) and 4 (bits 23:16). Successive start-flag strobes are period×divider cycles apart. A period of 0 behaves as 1.
- R4: Control bits 7:6 pick the pacer base. 11 uses DIV_SLOW clock cycles per count, 10 uses DIV_MID, 01 uses DIV_FAST, and 00 counts one per `extTick` pulse.
- R5: With control bit 2 clear (one-shot), the block issues each entry once in list order, sets end of scan on the last one, and goes idle.
- R6: With control bit 2 set (continuous), the block wraps to the first entry after the last and runs until stopped.
- R7: Command byte at offset 5: bit 7 arms, bit 5 resets the queue, bit 4 stops. Queue reset wins over stop, and stop wins over arm. An arm written while running is ignored and does not disturb the pacing.
- R8: A queue reset empties the list, returns the byte phase to low byte, and clears end of scan.
- R9: A stop ends running at the next clock edge. No strobe is issued after the cycle in which the stop is written.
- R10: An arm with an empty list is ignored and the block stays idle.
- R11: `statusReg` bit 7 is idle, bit 6 is running and bit 4 is end of scan, and all other bits are 0. End of scan is set with the strobe of the last entry and cleared by an accepted arm or a queue reset. `scanIrq` is end of scan gated by control bit 4.
- R12: No strobe follows a cycle with `convBusy` high, no strobe lasts longer than one cycle, and no strobe issues while idle.
- R13: The list holds DEPTH entries. Complete entries written beyond that are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write enable |
| wrAddr | input | 3 | Host register offset |
| wrData | input | 8 | Host write byte |
| extTick | input | 1 | External pacer base pulse, one cycle per count, already synchronous |
| convBusy | input | 1 | Converter busy; high blocks the next issue |
| convStrobe | output | 1 | One-cycle convert request |
| convChan | output | 4 | Channel of the issued entry |
| convGain | output | 2 | Gain code of the issued entry |
| convDiff | output | 1 | Differential flag of the issued entry |
| statusReg | output | 8 | Status byte (idle, running, end of scan) |
| scanIrq | output | 1 | End-of-scan interrupt level |

## Verification
The assertions assume that `convBusy` follows only the strobes and the converter's own timing, and that `extTick` is already a single-cycle synchronous pulse. They also assume the host never writes a command byte in the same cycle as reset is released. The bench drives `convBusy` only as a level held across whole windows, pulses `extTick` for exactly one cycle at negative edges, and waits for idle before reloading the list. Every pacing window it checks uses a period times divider larger than the scan's back-to-back length, so the start-flag spacing is exact.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  // host register offsets
  localparam logic [2:0] ADDR_ENTRY    = 3'd0;
  localparam logic [2:0] ADDR_CTRL     = 3'd1;
  localparam logic [2:0] ADDR_PACE_LO  = 3'd2;
  localparam logic [2:0] ADDR_CMD      = 3'd5;

  // control byte fields
  localparam int CTL_BASE_LSB = 6;
  localparam int CTL_EOS_IE   = 4;
  localparam int CTL_CONT     = 2;

  // command byte fields
  localparam int CMD_ARM  = 7;
  localparam int CMD_RSTQ = 5;
  localparam int CMD_STOP = 4;

  // status byte fields
  localparam int ST_IDLE = 7;
  localparam int ST_RUN  = 6;
  localparam int ST_EOS  = 4;

  typedef enum logic [1:0] {
    BASE_EXT  = 2'b00,
    BASE_FAST = 2'b01,
    BASE_MID  = 2'b10,
    BASE_SLOW = 2'b11
  } paceBase_e;

  typedef struct packed {
    logic diff;
    logic [1:0] gain;
    logic [3:0] chan;
    logic start;
  } scanEntry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic armLoad;
    logic issue;
    logic scanEnd;
  } seqStrobes_t;

endpackage

// File: rtl/scan_seq_datapath.sv
module scan_seq_datapath
  import scan_seq_pkg::*;
#(
  parameter int DEPTH       = 2048,
  parameter int PACER_BYTES = 3,
  parameter int DIV_FAST    = 1,
  parameter int DIV_MID     = 5,
  parameter int DIV_SLOW    = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic        extTick,
  input  logic        running,
  input  seqStrobes_t strb,
  output logic        armCmd,
  output logic        stopCmd,
  output logic        rstQCmd,
  output logic        listEmpty,
  output logic        curStart,
  output logic        curIsLast,
  output logic        contMode,
  output logic        tickPend,
  output logic        eosIntEn,
  output logic [3:0]  convChan,
  output logic [1:0]  convGain,
  output logic        convDiff
);

  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int PACER_W = 8 * PACER_BYTES;
  localparam int DIV_MAX = (DIV_SLOW > DIV_MID) ?
                           ((DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST) :
                           ((DIV_MID > DIV_FAST) ? DIV_MID : DIV_FAST);
  localparam int PRESC_W = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  // ---------------- host decode ----------------
  logic cmdWr, ctrlWr, entryWr;
  assign cmdWr   = wrEn && (wrAddr == ADDR_CMD);
  assign ctrlWr  = wrEn && (wrAddr == ADDR_CTRL);
  assign entryWr = wrEn && (wrAddr == ADDR_ENTRY);
  assign armCmd  = cmdWr && wrData[CMD_ARM];
  assign stopCmd = cmdWr && wrData[CMD_STOP];
  assign rstQCmd = cmdWr && wrData[CMD_RSTQ];

  // ---------------- control register ----------------
  paceBase_e baseSel;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseSel  <= BASE_EXT;
      eosIntEn <= 1'b0;
      contMode <= 1'b0;
    end else if (ctrlWr) begin
      baseSel  <= paceBase_e'(wrData[CTL_BASE_LSB +: 2]);
      eosIntEn <= wrData[CTL_EOS_IE];
      contMode <= wrData[CTL_CONT];
    end
  end

  // ---------------- pacer period bytes ----------------
  logic [7:0] periodByte [PACER_BYTES];
  logic [PACER_W-1:0] period;

  for (genvar b = 0; b < PACER_BYTES; b++) begin : g_period
    always_ff @(posedge clk) begin
      if (!rstN)
        periodByte[b] <= 8'd0;
      else if (wrEn && (wrAddr == 3'(ADDR_PACE_LO + b)))
        periodByte[b] <= wrData;
    end
  end

  always_comb begin
    period = '0;
    for (int b = 0; b < PACER_BYTES; b++)
      period[8*b +: 8] = periodByte[b];
  end

  // ---------------- entry queue ----------------
  logic             phaseHi;
  logic [7:0]       lowByte;
  logic [CNT_W-1:0] wrPtr;
  logic             entryCommit;
  scanEntry_t       newEntry;
  scanEntry_t       entryMem [DEPTH];
  logic [IDX_W-1:0] rdIdx;
  scanEntry_t       curEntry;

  assign entryCommit = entryWr && phaseHi && (wrPtr < DEPTH_C);
  assign newEntry    = '{diff: wrData[6], gain: wrData[5:4],
                         chan: wrData[3:0], start: lowByte[7]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseHi <= 1'b0;
      lowByte <= 8'd0;
      wrPtr   <= '0;
    end else if (rstQCmd) begin
      phaseHi <= 1'b0;
      wrPtr   <= '0;
    end else if (entryWr) begin
      phaseHi <= !phaseHi;
      if (!phaseHi)
        lowByte <= wrData;
      if (entryCommit)
        wrPtr <= wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (entryCommit)
      entryMem[wrPtr[IDX_W-1:0]] <= newEntry;
  end

  assign curEntry  = entryMem[rdIdx];
  assign curStart  = curEntry.start;
  assign listEmpty = (wrPtr == '0);
  assign curIsLast = ((CNT_W'(rdIdx) + 1'b1) == wrPtr);

  always_ff @(posedge clk) begin
    if (!rstN)
      rdIdx <= '0;
    else if (strb.armLoad)
      rdIdx <= '0;
    else if (strb.issue)
      rdIdx <= strb.scanEnd ? '0 : rdIdx + 1'b1;
  end

  // ---------------- pacer ----------------
  logic [PRESC_W-1:0] prescCnt, prescLimit;
  logic [PACER_W-1:0] paceCnt, paceLast;
  logic baseTick, paceTick, paceClr;

  always_comb begin
    unique case (baseSel)
      BASE_FAST: prescLimit = PRESC_W'(DIV_FAST - 1);
      BASE_MID:  prescLimit = PRESC_W'(DIV_MID - 1);
      BASE_SLOW: prescLimit = PRESC_W'(DIV_SLOW - 1);
      default:   prescLimit = '0;
    endcase
  end

  assign paceClr  = !running || strb.armLoad;
  assign baseTick = running &&
                    ((baseSel == BASE_EXT) ? extTick : (prescCnt == prescLimit));
  assign paceLast = (period == '0) ? '0 : period - 1'b1;
  assign paceTick = baseTick && (paceCnt >= paceLast);

  always_ff @(posedge clk) begin
    if (!rstN || paceClr) begin
      prescCnt <= '0;
      paceCnt  <= '0;
    end else begin
      if (baseSel != BASE_EXT)
        prescCnt <= (prescCnt == prescLimit) ? '0 : prescCnt + 1'b1;
      if (baseTick)
        paceCnt <= paceTick ? '0 : paceCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.armLoad)
      tickPend <= 1'b0;
    else
      tickPend <= paceTick || (tickPend && !(strb.issue && curStart));
  end

  // ---------------- converter select outputs ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      convChan <= '0;
      convGain <= '0;
      convDiff <= 1'b0;
    end else if (strb.issue) begin
      convChan <= curEntry.chan;
      convGain <= curEntry.gain;
      convDiff <= curEntry.diff;
    end
  end

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        armCmd,
  input  logic        stopCmd,
  input  logic        rstQCmd,
  input  logic        listEmpty,
  input  logic        curStart,
  input  logic        curIsLast,
  input  logic        contMode,
  input  logic        tickPend,
  input  logic        convBusy,
  output seqStrobes_t strb,
  output logic        running,
  output logic        convStrobe,
  output logic        eosFlag
);

  logic armAccept, issue, ready;

  // queue reset beats stop, stop beats arm
  assign armAccept = armCmd && !stopCmd && !rstQCmd && !listEmpty && !running;
  assign ready     = curStart ? tickPend : 1'b1;
  // the cycle showing a strobe is a hold-off cycle for the converter to answer
  assign issue     = running && !convStrobe && !convBusy && ready;

  assign strb.armLoad = armAccept;
  assign strb.issue   = issue;
  assign strb.scanEnd = issue && curIsLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (armAccept) begin
      running <= 1'b1;
    end else if (running) begin
      if (stopCmd || rstQCmd)
        running <= 1'b0;
      else if (issue && curIsLast && !contMode)
        running <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      convStrobe <= 1'b0;
    else
      convStrobe <= issue;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      eosFlag <= 1'b0;
    else if (armAccept || rstQCmd)
      eosFlag <= 1'b0;
    else if (issue && curIsLast)
      eosFlag <= 1'b1;
  end

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_seq_pkg::*;
#(
  parameter int DEPTH       = 2048,
  parameter int PACER_BYTES = 3,
  parameter int DIV_FAST    = 1,
  parameter int DIV_MID     = 5,
  parameter int DIV_SLOW    = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       extTick,
  input  logic       convBusy,
  output logic       convStrobe,
  output logic [3:0] convChan,
  output logic [1:0] convGain,
  output logic       convDiff,
  output logic [7:0] statusReg,
  output logic       scanIrq
);

  seqStrobes_t strb;
  logic armCmd, stopCmd, rstQCmd, listEmpty, curStart, curIsLast;
  logic contMode, tickPend, eosIntEn, running, eosFlag;

  scan_seq_datapath #(
    .DEPTH(DEPTH), .PACER_BYTES(PACER_BYTES),
    .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extTick(extTick), .running(running), .strb(strb),
    .armCmd(armCmd), .stopCmd(stopCmd), .rstQCmd(rstQCmd),
    .listEmpty(listEmpty), .curStart(curStart), .curIsLast(curIsLast),
    .contMode(contMode), .tickPend(tickPend), .eosIntEn(eosIntEn),
    .convChan(convChan), .convGain(convGain), .convDiff(convDiff)
  );

  scan_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .armCmd(armCmd), .stopCmd(stopCmd),
    .rstQCmd(rstQCmd), .listEmpty(listEmpty), .curStart(curStart),
    .curIsLast(curIsLast), .contMode(contMode), .tickPend(tickPend),
    .convBusy(convBusy), .strb(strb), .running(running),
    .convStrobe(convStrobe), .eosFlag(eosFlag)
  );

  always_comb begin
    statusReg          = 8'h00;
    statusReg[ST_IDLE] = !running;
    statusReg[ST_RUN]  = running;
    statusReg[ST_EOS]  = eosFlag;
  end

  assign scanIrq = eosFlag && eosIntEn;

endmodule

// File: rtl/scan_seq_checks.sv
module scan_seq_checks
  import scan_seq_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [2:0] wrAddr,
  input logic [7:0] wrData,
  input logic       convBusy,
  input logic       convStrobe,
  input logic [3:0] convChan,
  input logic [1:0] convGain,
  input logic       convDiff,
  input logic [7:0] statusReg
);

  // R12
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStrobe |=> !convStrobe);

  // R12
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    convBusy |=> !convStrobe);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statusReg[ST_RUN] |=> !convStrobe);

  // R11
  eos_with_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[ST_EOS]) |-> convStrobe);

  // R9
  stop_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_CMD && wrData[CMD_STOP]) |=> !statusReg[ST_RUN]);

  // R8
  qreset_eos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_CMD && wrData[CMD_RSTQ]) |=> !statusReg[ST_EOS]);

  // R1
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !convStrobe |-> $stable({convChan, convGain, convDiff}));

endmodule

bind scan_sequencer scan_seq_checks u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .convBusy(convBusy), .convStrobe(convStrobe), .convChan(convChan),
  .convGain(convGain), .convDiff(convDiff), .statusReg(statusReg)
);

// File: tb/scan_sequencer_test.sv
module scan_sequencer_test;

  localparam int DEPTH = 8;
  localparam int DF = 1, DM = 2, DS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic extTick = 1'b0;
  logic convBusy = 1'b0;
  logic convStrobe, convDiff, scanIrq;
  logic [3:0] convChan;
  logic [1:0] convGain;
  logic [7:0] statusReg;

  int nChecks = 0, nFail = 0, cyc = 0, armCyc = 0, nStr = 0;
  int sCyc [64];
  int sChan [64];
  int sGain [64];
  int sDiff [64];
  bit done = 0;

  scan_sequencer #(.DEPTH(DEPTH), .DIV_FAST(DF), .DIV_MID(DM), .DIV_SLOW(DS)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extTick(extTick), .convBusy(convBusy), .convStrobe(convStrobe),
    .convChan(convChan), .convGain(convGain), .convDiff(convDiff),
    .statusReg(statusReg), .scanIrq(scanIrq)
  );

  always #4 clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial forever begin
    @(negedge clk);
    if (rstN && convStrobe && nStr < 64) begin
      sCyc[nStr] = cyc; sChan[nStr] = convChan;
      sGain[nStr] = convGain; sDiff[nStr] = convDiff;
      nStr++;
    end
  end

  task automatic checkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic addEntry(input bit st, input int ch, input int g, input bit df);
    wr(3'd0, {st, 7'd0});
    wr(3'd0, {1'b0, df, 2'(g), 4'(ch)});
  endtask

  task automatic setPeriod(input int p);
    wr(3'd2, 8'(p));
    wr(3'd3, 8'(p >> 8));
    wr(3'd4, 8'(p >> 16));
  endtask

  task automatic arm();
    wr(3'd5, 8'h80);
    armCyc = cyc;
  endtask

  task automatic fresh();
    wr(3'd5, 8'h20);
    @(negedge clk);
    nStr = 0;
  endtask

  task automatic idleWait(input int lim);
    for (int i = 0; i < lim && statusReg[6]; i++) @(negedge clk);
  endtask

  task automatic strWait(input int n, input int lim);
    for (int i = 0; i < lim && nStr < n; i++) @(negedge clk);
  endtask

  task automatic pulseExt();
    @(negedge clk); extTick = 1'b1;
    @(negedge clk); extTick = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finishRun();
    end
  end

  initial begin
    int expC[4] = '{2, 7, 0, 15};
    int expG[4] = '{1, 3, 2, 0};
    int expD[4] = '{0, 1, 0, 1};
    int n0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    checkEq("R11 reset status", statusReg, 8'h80);
    checkEq("R11 reset irq", scanIrq, 0);
    checkEq("R12 reset strobe", convStrobe, 0);

    // R10 arm with empty list
    arm(); repeat (3) @(negedge clk);
    checkEq("R10 empty arm status", statusReg, 8'h80);

    // per-scan pacing, one-shot, fast base
    fresh();
    wr(3'd1, 8'h50);
    setPeriod(6);
    for (int i = 0; i < 4; i++) addEntry(i == 0, expC[i], expG[i], expD[i] != 0);
    arm();
    idleWait(200);
    repeat (4) @(negedge clk);
    checkEq("R5 one-shot strobe count", nStr, 4);
    checkEq("R2 first start offset", sCyc[0] - armCyc, 6 * DF + 1);
    for (int i = 1; i < 4; i++) checkEq("R2 back-to-back spacing", sCyc[i] - sCyc[i-1], 2);
    for (int i = 0; i < 4; i++) begin
      checkEq("R1 chan", sChan[i], expC[i]);
      checkEq("R1 gain", sGain[i], expG[i]);
      checkEq("R1 diff", sDiff[i], expD[i]);
    end
    checkEq("R5 R11 done status", statusReg, 8'h90);
    checkEq("R11 irq enabled", scanIrq, 1);

    // per-conversion pacing, continuous, mid base, stop, re-arm ignored
    fresh();
    checkEq("R8 reset clears eos", statusReg, 8'h80);
    wr(3'd1, 8'h84);
    setPeriod(5);
    for (int i = 0; i < 3; i++) addEntry(1, 9 + i, i, 0);
    arm();
    strWait(3, 400);
    wr(3'd5, 8'h80); // R7 arm while running ignored
    strWait(7, 400);
    checkEq("R3 R4 first offset mid", sCyc[0] - armCyc, 5 * DM + 1);
    for (int i = 1; i < 7; i++) checkEq("R3 R4 R7 paced spacing mid", sCyc[i] - sCyc[i-1], 5 * DM);
    for (int i = 0; i < 7; i++) checkEq("R6 wrap order", sChan[i], 9 + (i % 3));
    wr(3'd5, 8'h10);
    @(negedge clk);
    n0 = nStr;
    repeat (40) @(negedge clk);
    checkEq("R9 no strobe after stop", nStr, n0);
    checkEq("R9 R11 stopped status", statusReg, 8'h90);

    // slow base, eos irq masked
    fresh();
    wr(3'd1, 8'hC0);
    setPeriod(3);
    addEntry(1, 3, 0, 0); addEntry(1, 4, 0, 0);
    arm();
    idleWait(400);
    repeat (3) @(negedge clk);
    checkEq("R4 slow count", nStr, 2);
    checkEq("R4 slow first offset", sCyc[0] - armCyc, 3 * DS + 1);
    checkEq("R4 slow spacing", sCyc[1] - sCyc[0], 3 * DS);
    checkEq("R11 irq masked", scanIrq, 0);
    checkEq("R11 eos set masked", statusReg, 8'h90);

    // period zero acts as one
    fresh();
    setPeriod(0);
    addEntry(1, 1, 0, 0); addEntry(1, 2, 0, 0);
    arm();
    idleWait(400);
    repeat (3) @(negedge clk);
    checkEq("R3 zero period count", nStr, 2);
    checkEq("R3 zero period spacing", sCyc[1] - sCyc[0], DS);

    // external base
    fresh();
    wr(3'd1, 8'h00);
    setPeriod(2);
    addEntry(1, 6, 1, 1); addEntry(1, 8, 2, 0);
    arm();
    repeat (10) @(negedge clk);
    checkEq("R4 ext no pulse", nStr, 0);
    pulseExt();
    checkEq("R4 ext one pulse", nStr, 0);
    pulseExt();
    checkEq("R4 ext two pulses", nStr, 1);
    pulseExt(); pulseExt();
    checkEq("R4 ext four pulses", nStr, 2);
    checkEq("R5 ext done", statusReg, 8'h90);

    // queue reset mid byte pair
    fresh();
    wr(3'd1, 8'h40);
    setPeriod(1);
    wr(3'd0, 8'h80);
    fresh();
    addEntry(1, 5, 2, 1);
    arm();
    idleWait(100);
    repeat (3) @(negedge clk);
    checkEq("R8 phase reset count", nStr, 1);
    checkEq("R8 phase reset chan", sChan[0], 5);
    checkEq("R8 phase reset gain", sGain[0], 2);

    // capacity
    fresh();
    for (int i = 0; i < 10; i++) addEntry(i == 0, i, 0, 0);
    arm();
    idleWait(200);
    repeat (3) @(negedge clk);
    checkEq("R13 capacity count", nStr, DEPTH);
    for (int i = 0; i < DEPTH; i++) checkEq("R13 capacity chan", sChan[i], i);

    // command priority
    wr(3'd5, 8'h90);
    @(negedge clk);
    checkEq("R7 stop beats arm", statusReg[6], 0);
    wr(3'd5, 8'hA0);
    wr(3'd5, 8'h80);
    @(negedge clk);
    checkEq("R7 R10 reset beats arm", statusReg[6], 0);

    // busy hold-off
    fresh();
    setPeriod(2);
    addEntry(1, 11, 0, 0); addEntry(0, 12, 0, 0); addEntry(0, 13, 0, 0);
    convBusy = 1'b1;
    arm();
    repeat (30) @(negedge clk);
    checkEq("R12 busy blocks", nStr, 0);
    convBusy = 1'b0;
    idleWait(100);
    repeat (3) @(negedge clk);
    checkEq("R12 after busy count", nStr, 3);
    checkEq("R2 after busy spacing", sCyc[2] - sCyc[1], 2);

    done = 1;
    finishRun();
  end

endmodule